// File: doc/BRIEF.md
# Dynamic Test-Waveform Harmonic Synthesizer

This block turns a nominal angular position into one sample of a composite test waveform. Each accepted tick carries a phase word from an external phase accumulator. A mode input picks what is added to that phase before synthesis: nothing, a growing quadratic phase that models a linear frequency ramp, or a cosine phase modulation. The resulting fundamental angle feeds a bank of harmonic channels. Each channel multiplies the angle by its own integer order, adds its own phase offset, looks the result up in a shared cosine table and scales it by its own amplitude. The channel terms are added into one signed sample, which saturates at the limits of the output width.

The ramp phase comes from two chained accumulators. A frequency offset grows by a programmed rate each sample, is held inside a programmed band, and is integrated into phase. The modulation has its own phase accumulator. Its cosine is read from the same table as the harmonic channels, in a slot that comes before them. The channels are evaluated one after another, so a sample needs a few clock cycles. This is far shorter than a 100 us sample period.

The tick input and the sample output are valid/ready streams. A tick is taken only when `tick_valid` and `tick_ready` are both high. `tick_ready` stays low from that acceptance until the finished sample has been taken. `out_valid` stays high, and `out_sample` does not change, until `out_ready` is seen high at a clock edge. A consumer that stalls therefore stalls tick acceptance, and no sample is ever dropped. The mode, ramp, modulation and harmonic inputs are plain control pins. They must be held steady from the accepting edge until `out_valid` rises.

Top module: `dts_synth`

## Requirements
- R1: After reset, `out_valid` is 0 and `tick_ready` is 1.
- R2: A tick is accepted on an edge where `tick_valid` and `tick_ready` are both high. `out_valid` rises NH+1 clock edges after that edge. `tick_ready` is low from the accepting edge until the sample is taken. While `out_ready` is low, `out_valid` stays high and `out_sample` stays unchanged. The edge where `out_valid` and `out_ready` are both high clears `out_valid`.
- R3: The cosine lookup uses the top LUT_BITS bits u of a PW-bit angle word, where a full turn is 2^PW. It returns round(32767·cos(2π·u/2^LUT_BITS)) as a signed 16-bit value.
- R4: Channel k uses `harm_order[k*OW +: OW]`, `harm_phase[k*PW +: PW]` and the signed `harm_amp[k*SW +: SW]`. Its angle is (fundamental·order + phase) mod 2^PW. Its term is (amp·cos) arithmetically shifted right by 15. An order of 0 gives a constant term amp·cos(phase).
- R5: The sample is the sum of all NH channel terms, saturated to the signed SW-bit range (-32768..32767 for SW=16). It does not wrap.
- R6: With `pert_mode` 0 or 3 the fundamental equals `base_phase`. Both the ramp state and the modulation state are cleared.
- R7: With `pert_mode` 1 (ramp), sample k in an unbroken run uses perturbation p_k, with p_0 = 0 and f_0 = 0. After each sample, f_{k+1} = clamp(f_k + `ramp_rate`) and p_{k+1} = p_k + f_{k+1}, both mod 2^PW. Any sample taken in another mode restarts the run.
- R8: The ramp frequency offset f is held inside ±`ramp_limit`. `ramp_limit` must be below 2^(PW-1).
- R9: With `pert_mode` 2 (modulation), sample k in an unbroken run uses perturbation −((`mod_depth`·cos(m_k)) >>> 15), with m_0 = 0 and m_{k+1} = m_k + `mod_step`. The cosine is taken through the table of R3. Any sample taken in another mode restarts the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_valid | input | 1 | A sample tick with its base phase is offered |
| tick_ready | output | 1 | Block can accept a tick |
| base_phase | input | PW | Nominal angular position, full turn = 2^PW |
| pert_mode | input | 2 | 0/3 none, 1 frequency ramp, 2 phase modulation |
| ramp_rate | input | PW | Signed growth of the frequency offset per sample |
| ramp_limit | input | PW | Bound on the magnitude of the frequency offset |
| mod_step | input | PW | Modulation phase increment per sample |
| mod_depth | input | PW | Modulation depth in phase units |
| harm_order | input | NH*OW | Harmonic order per channel |
| harm_phase | input | NH*PW | Phase offset per channel |
| harm_amp | input | NH*SW | Signed Q15 amplitude per channel |
| out_valid | output | 1 | A finished sample is present |
| out_ready | input | 1 | Consumer takes the sample |
| out_sample | output | SW | Saturated signed sample |

## Verification
Single-channel fundamentals at angles of 0, a quarter turn and a half turn pin the table's sign and quadrant mirroring. An order-zero channel separates the harmonic product path from the phase-offset path. Four full-scale DC channels, first positive and then negative, show whether the sum saturates or wraps. Random sets of orders, phases and amplitudes in plain mode exercise the channel sum as a whole. Long ramp runs with positive and negative rates reach the frequency band, which exposes the clamp and the integration order. Modulation runs, together with direct mode switches, show whether the accumulators restart. Randomly delayed `out_ready` shows whether the sample is held and acceptance stalls.

// File: rtl/dts_pkg.sv
package dts_pkg;

  typedef enum logic [1:0] {
    PM_NONE     = 2'd0,
    PM_RAMP     = 2'd1,
    PM_MOD      = 2'd2,
    PM_NONE_ALT = 2'd3
  } pert_mode_e;

  // pi * 2^30, used to place table points on a Q30 angle grid
  localparam longint PI_Q30 = 64'sd3373259426;

  // Quarter-wave entry idx of qn: round(32767*cos(idx*pi/(2*qn))), Taylor series in Q30
  function automatic logic signed [15:0] cos_entry(input int idx, input int qn);
    longint x, x2, term, sum;
    x    = (longint'(idx) * PI_Q30) / longint'(2 * qn);
    x2   = (x * x) >>> 30;
    term = longint'(1) <<< 30;
    sum  = term;
    for (int k = 1; k <= 8; k++) begin
      term = -((term * x2) >>> 30) / longint'((2 * k - 1) * (2 * k));
      sum  = sum + term;
    end
    return 16'((sum * 32767 + (longint'(1) <<< 29)) >>> 30);
  endfunction

endpackage

// File: rtl/dts_cos_rom.sv
module dts_cos_rom #(
  parameter int PW       = 24,
  parameter int LUT_BITS = 8
) (
  input  logic [PW-1:0]     angle,
  output logic signed [15:0] cos_val
);
  import dts_pkg::*;

  localparam int QB = LUT_BITS - 2;
  localparam int QN = 1 << QB;

  logic signed [15:0] rom [0:QN];
  logic [LUT_BITS-1:0] idx;
  logic [1:0]          quad;
  logic [QB:0]         off;
  logic [QB:0]         mirror;

  for (genvar g = 0; g <= QN; g++) begin : g_rom
    assign rom[g] = cos_entry(g, QN);
  end

  assign idx    = LUT_BITS'(angle >> (PW - LUT_BITS));
  assign quad   = idx[LUT_BITS-1 -: 2];
  assign off    = {1'b0, idx[QB-1:0]};
  assign mirror = (QB+1)'(QN) - off;

  always_comb begin
    case (quad)
      2'd0:    cos_val =  rom[off];
      2'd1:    cos_val = -rom[mirror];
      2'd2:    cos_val = -rom[off];
      default: cos_val =  rom[mirror];
    endcase
  end

  // R3: table output never leaves the symmetric Q15 range
  always_comb begin
    assert_table_range_R3: assert (cos_val != -16'sd32768);
  end

endmodule

// File: rtl/dts_perturb.sv
module dts_perturb #(
  parameter int PW = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 step,
  input  logic [1:0]           mode,
  input  logic signed [PW-1:0] ramp_rate,
  input  logic [PW-1:0]        ramp_limit,
  input  logic [PW-1:0]        mod_step,
  input  logic [PW-1:0]        mod_depth,
  input  logic signed [15:0]   mod_cos,
  output logic [PW-1:0]        mod_angle,
  output logic [PW-1:0]        pert
);
  import dts_pkg::*;

  logic signed [PW-1:0] freq_q;
  logic [PW-1:0]        ramp_ph_q;
  logic [PW-1:0]        mod_ph_q;
  logic signed [PW:0]   fsum;
  logic signed [PW:0]   lim;
  logic signed [PW-1:0] f_next;
  logic signed [PW+16:0] mprod;
  logic [PW-1:0]        mscaled;

  assign lim  = $signed({1'b0, ramp_limit});
  assign fsum = freq_q + ramp_rate;

  always_comb begin
    if (fsum > lim)       f_next = PW'(lim);
    else if (fsum < -lim) f_next = PW'(-lim);
    else                  f_next = PW'(fsum);
  end

  assign mprod   = $signed({1'b0, mod_depth}) * mod_cos;
  assign mscaled = PW'(mprod >>> 15);
  assign mod_angle = mod_ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      freq_q    <= '0;
      ramp_ph_q <= '0;
      mod_ph_q  <= '0;
      pert      <= '0;
    end else if (step) begin
      case (mode)
        PM_RAMP: begin
          pert      <= ramp_ph_q;
          freq_q    <= f_next;
          ramp_ph_q <= ramp_ph_q + $unsigned(f_next);
          mod_ph_q  <= '0;
        end
        PM_MOD: begin
          pert      <= -mscaled;
          mod_ph_q  <= mod_ph_q + mod_step;
          freq_q    <= '0;
          ramp_ph_q <= '0;
        end
        default: begin
          pert      <= '0;
          freq_q    <= '0;
          ramp_ph_q <= '0;
          mod_ph_q  <= '0;
        end
      endcase
    end
  end

  assert_ramp_band_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (step && mode == PM_RAMP) |=>
      ($signed({freq_q[PW-1], freq_q}) <= $past(lim)) &&
      ($signed({freq_q[PW-1], freq_q}) >= -$past(lim)));

  assert_plain_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && (mode == PM_NONE || mode == PM_NONE_ALT)) |=>
      (pert == '0) && (freq_q == '0) && (mod_ph_q == '0));

  assert_mod_clears_ramp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (step && mode == PM_MOD) |=> (ramp_ph_q == '0) && (freq_q == '0));

endmodule

// File: rtl/dts_synth.sv
module dts_synth #(
  parameter int PW       = 24,
  parameter int NH       = 4,
  parameter int OW       = 4,
  parameter int SW       = 16,
  parameter int LUT_BITS = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_valid,
  output logic               tick_ready,
  input  logic [PW-1:0]      base_phase,
  input  logic [1:0]         pert_mode,
  input  logic [PW-1:0]      ramp_rate,
  input  logic [PW-1:0]      ramp_limit,
  input  logic [PW-1:0]      mod_step,
  input  logic [PW-1:0]      mod_depth,
  input  logic [NH*OW-1:0]   harm_order,
  input  logic [NH*PW-1:0]   harm_phase,
  input  logic [NH*SW-1:0]   harm_amp,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [SW-1:0]      out_sample
);
  import dts_pkg::*;

  localparam int CW   = 16;
  localparam int CHW  = (NH > 1) ? $clog2(NH) : 1;
  localparam int ACCW = SW + CHW + 2;
  localparam logic signed [ACCW-1:0] SMAX = ACCW'((longint'(1) <<< (SW-1)) - 1);
  localparam logic signed [ACCW-1:0] SMIN = -ACCW'(longint'(1) <<< (SW-1));

  typedef enum logic [1:0] {ST_IDLE, ST_PERT, ST_HARM} state_e;

  state_e               state;
  logic [CHW-1:0]       ch;
  logic [PW-1:0]        base_q;
  logic [PW-1:0]        pert;
  logic [PW-1:0]        mod_angle;
  logic [PW-1:0]        fund;
  logic [PW-1:0]        harm_angle;
  logic [PW-1:0]        rom_angle;
  logic signed [CW-1:0] cos_val;
  logic [OW-1:0]        ord_sel;
  logic [PW-1:0]        ph_sel;
  logic signed [SW-1:0] amp_sel;
  logic signed [SW+CW-1:0] prod;
  logic signed [SW:0]   term;
  logic signed [ACCW-1:0] acc;
  logic signed [ACCW-1:0] sum_next;
  logic [SW-1:0]        sat_val;

  assign tick_ready = (state == ST_IDLE) && !out_valid;

  assign ord_sel = harm_order[ch*OW +: OW];
  assign ph_sel  = harm_phase[ch*PW +: PW];
  assign amp_sel = $signed(harm_amp[ch*SW +: SW]);

  assign fund       = base_q + pert;
  assign harm_angle = fund * PW'(ord_sel) + ph_sel;
  assign rom_angle  = (state == ST_PERT) ? mod_angle : harm_angle;

  dts_cos_rom #(.PW(PW), .LUT_BITS(LUT_BITS)) u_rom (
    .angle   (rom_angle),
    .cos_val (cos_val)
  );

  dts_perturb #(.PW(PW)) u_pert (
    .clk        (clk),
    .rst_n      (rst_n),
    .step       (state == ST_PERT),
    .mode       (pert_mode),
    .ramp_rate  ($signed(ramp_rate)),
    .ramp_limit (ramp_limit),
    .mod_step   (mod_step),
    .mod_depth  (mod_depth),
    .mod_cos    (cos_val),
    .mod_angle  (mod_angle),
    .pert       (pert)
  );

  assign prod     = amp_sel * cos_val;
  assign term     = (SW+1)'(prod >>> (CW-1));
  assign sum_next = acc + term;

  always_comb begin
    if (sum_next > SMAX)      sat_val = SW'(SMAX);
    else if (sum_next < SMIN) sat_val = SW'(SMIN);
    else                      sat_val = SW'(sum_next);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      ch         <= '0;
      base_q     <= '0;
      acc        <= '0;
      out_valid  <= 1'b0;
      out_sample <= '0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      case (state)
        ST_IDLE: if (tick_valid && tick_ready) begin
          base_q <= base_phase;
          state  <= ST_PERT;
        end
        ST_PERT: begin
          ch    <= '0;
          acc   <= '0;
          state <= ST_HARM;
        end
        default: begin
          if (ch == CHW'(NH - 1)) begin
            out_sample <= sat_val;
            out_valid  <= 1'b1;
            state      <= ST_IDLE;
          end else begin
            acc <= sum_next;
            ch  <= ch + 1'b1;
          end
        end
      endcase
    end
  end

  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_valid && tick_ready) |=> !tick_ready);

  assert_hold_sample_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sample)));

  assert_valid_from_last_channel_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> ($past(state) == ST_HARM));

  assert_no_accept_while_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !tick_ready);

endmodule

// File: tb/dts_synth_test.sv
`timescale 1ns/1ps
module dts_synth_test;
  localparam int PW = 24, NH = 4, OW = 4, SW = 16, LB = 8;
  localparam longint MASK = (longint'(1) <<< PW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic tick_valid = 1'b0;
  logic tick_ready;
  logic [PW-1:0] base_phase = '0;
  logic [1:0] pert_mode = 2'd0;
  logic [PW-1:0] ramp_rate = '0, ramp_limit = '0, mod_step = '0, mod_depth = '0;
  logic [NH*OW-1:0] harm_order = '0;
  logic [NH*PW-1:0] harm_phase = '0;
  logic [NH*SW-1:0] harm_amp = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [SW-1:0] out_sample;

  dts_synth #(.PW(PW), .NH(NH), .OW(OW), .SW(SW), .LUT_BITS(LB)) uut (
    .clk(clk), .rst_n(rst_n), .tick_valid(tick_valid), .tick_ready(tick_ready),
    .base_phase(base_phase), .pert_mode(pert_mode), .ramp_rate(ramp_rate),
    .ramp_limit(ramp_limit), .mod_step(mod_step), .mod_depth(mod_depth),
    .harm_order(harm_order), .harm_phase(harm_phase), .harm_amp(harm_amp),
    .out_valid(out_valid), .out_ready(out_ready), .out_sample(out_sample)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  longint mf = 0, mp = 0, mm = 0;

  task automatic check(input string req, input longint act, input longint exp, input longint tol);
    checks++;
    if (act - exp > tol || exp - act > tol) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint cosq(input longint u);
    real a;
    a = 2.0 * 3.14159265358979 * real'(u) / real'(1 << LB);
    return longint'(int'(32767.0 * $cos(a)));
  endfunction

  function automatic longint sx(input longint v, input int w);
    longint m;
    m = v & ((longint'(1) <<< w) - 1);
    if (m >= (longint'(1) <<< (w - 1))) m = m - (longint'(1) <<< w);
    return m;
  endfunction

  // perturbation for the next sample per R6/R7/R8/R9, advancing the model state
  function automatic longint next_pert();
    longint p, fn, lim, c;
    if (pert_mode == 2'd1) begin
      p = mp;
      lim = longint'(ramp_limit);
      fn = mf + sx(longint'(ramp_rate), PW);
      if (fn > lim) fn = lim;
      if (fn < -lim) fn = -lim;
      mf = fn;
      mp = (mp + fn) & MASK;
      mm = 0;
    end else if (pert_mode == 2'd2) begin
      c = cosq(mm >>> (PW - LB));
      p = (-((longint'(mod_depth) * c) >>> 15)) & MASK;
      mm = (mm + longint'(mod_step)) & MASK;
      mf = 0; mp = 0;
    end else begin
      p = 0; mf = 0; mp = 0; mm = 0;
    end
    return p;
  endfunction

  // sample value per R3/R4/R5
  function automatic longint model_out(input longint base, input longint pert);
    longint fund, ang, c, sum, a, o, ph;
    fund = (base + pert) & MASK;
    sum = 0;
    for (int k = 0; k < NH; k++) begin
      o  = longint'(harm_order[k*OW +: OW]);
      ph = longint'(harm_phase[k*PW +: PW]);
      a  = sx(longint'(harm_amp[k*SW +: SW]), SW);
      ang = (fund * o + ph) & MASK;
      c = cosq(ang >>> (PW - LB));
      sum = sum + ((a * c) >>> 15);
    end
    if (sum > 32767) sum = 32767;
    if (sum < -32768) sum = -32768;
    return sum;
  endfunction

  task automatic run_sample(input longint base, input string req, input int hold);
    longint pert, e, held;
    int lat;
    pert = next_pert();
    e = model_out(base, pert);
    @(negedge clk);
    check("R2 ready before tick", longint'(tick_ready), 1, 0);
    tick_valid = 1'b1;
    base_phase = PW'(base);
    @(posedge clk);
    @(negedge clk);
    tick_valid = 1'b0;
    check("R2 ready low while busy", longint'(tick_ready), 0, 0);
    lat = 0;
    while (!out_valid && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    check("R2 latency", longint'(lat), NH + 1, 0);
    check(req, sx(longint'(out_sample), SW), e, 4);
    held = longint'(out_sample);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check("R2 valid held", longint'(out_valid), 1, 0);
      check("R2 sample stable", longint'(out_sample), held, 0);
      check("R2 ready low while full", longint'(tick_ready), 0, 0);
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    check("R2 valid cleared", longint'(out_valid), 0, 0);
  endtask

  task automatic set_ch(input int k, input int ord, input longint ph, input longint amp);
    harm_order[k*OW +: OW] = OW'(ord);
    harm_phase[k*PW +: PW] = PW'(ph);
    harm_amp[k*SW +: SW]   = SW'(amp);
  endtask

  task automatic clear_ch();
    for (int k = 0; k < NH; k++) set_ch(k, 0, 0, 0);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    longint b;
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    check("R1 out_valid in reset", longint'(out_valid), 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 out_valid after reset", longint'(out_valid), 0, 0);
    check("R1 tick_ready after reset", longint'(tick_ready), 1, 0);

    // R3/R4: single fundamental at quadrant corners
    clear_ch();
    set_ch(0, 1, 0, 32767);
    pert_mode = 2'd0;
    run_sample(0, "R3 cos at 0", 0);
    run_sample(longint'(1) <<< (PW - 2), "R3 cos at quarter", 1);
    run_sample(longint'(1) <<< (PW - 1), "R3 cos at half", 0);
    run_sample(longint'(3) <<< (PW - 2), "R3 cos at three quarters", 0);
    // R4: order 0 gives a DC term from the channel phase
    clear_ch();
    set_ch(1, 0, longint'(1) <<< (PW - 3), 10000);
    run_sample(12345, "R4 order zero DC", 0);
    // R4: third harmonic with phase and negative amplitude
    clear_ch();
    set_ch(2, 3, 777777, -20000);
    run_sample(1000000, "R4 third harmonic", 2);
    // R5: saturation both ways
    for (int k = 0; k < NH; k++) set_ch(k, 0, 0, 32767);
    run_sample(0, "R5 saturate high", 0);
    for (int k = 0; k < NH; k++) set_ch(k, 0, longint'(1) <<< (PW - 1), 32767);
    run_sample(0, "R5 saturate low", 0);
    for (int k = 0; k < NH; k++) set_ch(k, 0, 0, -32768);
    run_sample(0, "R5 saturate low negative amp", 0);

    // R4/R5/R6: random plain-mode samples
    for (int i = 0; i < 30; i++) begin
      for (int k = 0; k < NH; k++)
        set_ch(k, int'($urandom_range(0, 15)), longint'($urandom) & MASK,
               sx(longint'($urandom), SW));
      pert_mode = ($urandom_range(0, 1) == 0) ? 2'd0 : 2'd3;
      run_sample(longint'($urandom) & MASK, "R6 plain random", int'($urandom_range(0, 3)));
    end

    // R7/R8: ramp runs, positive then negative rate, reaching the band
    clear_ch();
    set_ch(0, 1, 0, 20000);
    set_ch(1, 3, 4000000, 6000);
    ramp_rate = PW'(37);
    ramp_limit = PW'(400);
    pert_mode = 2'd1;
    b = 0;
    for (int i = 0; i < 25; i++) begin
      run_sample(b, "R7 ramp positive", 0);
      b = (b + 335544) & MASK;
    end
    pert_mode = 2'd0;
    run_sample(b, "R6 plain between ramps", 0);
    ramp_rate = PW'(-4000);
    ramp_limit = PW'(30000);
    pert_mode = 2'd1;
    for (int i = 0; i < 25; i++) begin
      run_sample(b, "R8 ramp negative to band", int'($urandom_range(0, 2)));
      b = (b + 335544) & MASK;
    end

    // R9: modulation run
    mod_step = PW'(335544);
    mod_depth = PW'(268435);
    pert_mode = 2'd2;
    for (int i = 0; i < 25; i++) begin
      run_sample(b, "R9 modulation", 0);
      b = (b + 335544) & MASK;
    end
    // R7: direct switch from modulation to ramp restarts the ramp
    ramp_rate = PW'(5000);
    pert_mode = 2'd1;
    for (int i = 0; i < 5; i++) begin
      run_sample(b, "R7 restart after modulation", 0);
      b = (b + 335544) & MASK;
    end
    // R9: switch back restarts the modulation phase
    pert_mode = 2'd2;
    mod_depth = PW'(2000000);
    for (int i = 0; i < 6; i++) begin
      run_sample(b, "R9 restart after ramp", 1);
      b = (b + 335544) & MASK;
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule